// File: doc/BRIEF.md
# Low-Power Halt Release Controller

This block decides when a halted CPU may wake and what the CPU does next. When the CPU executes its halt instruction it pulses `halt_req`, and the controller records the requested low-power mode. The modes are a programmable IDLE2, IDLE1 and STOP. While halted, the controller watches the interrupt request lines, the non-maskable interrupt and the watchdog interrupt. It wakes the CPU with a one-cycle `wake` pulse. `wake_service` tells the CPU which of two things to do next. At 1, the CPU services the interrupt. At 0, it resumes at the instruction after the halt and no interrupt is taken.

A request line is enabled when its 3-bit priority level is greater than or equal to the CPU's 3-bit interrupt mask, and masked otherwise. A masked request can still end the halt, but it is not serviced. The non-maskable and watchdog interrupts are always treated as enabled. Leaving STOP is delayed by an oscillator warm-up interval. A programmable down-counter models this interval. `osc_off` shows that the oscillator is stopped, and `warming` shows that the warm-up count is running.

The state machine has three states. RUN goes to HALT on `halt_req`. HALT goes back to RUN with a wake pulse when a qualified source appears in IDLE2 or IDLE1. HALT goes to WARMUP when a qualified source appears in STOP. WARMUP goes to RUN with a wake pulse when the counter reaches zero. An asynchronous reset forces RUN from any state.

Top module: `halt_wake_ctrl`

## Requirements
- R1: Reset (rst_n low) forces halted, wake, wake_service, osc_off and warming to 0 immediately, from any state including warm-up. No wake pulse is issued for a reset release, and the block stays running afterwards.
- R2: A `halt_req` sampled while running makes `halted` 1 from the next cycle and captures `halt_mode`. The mode codes are 0 = IDLE2, 1 = IDLE1, and 2 or 3 = STOP. `osc_off` is 1 while halted in STOP and 0 while halted in IDLE2 or IDLE1.
- R3: In IDLE2 or IDLE1, a qualified request whose level (irq_level bits 3i+2..3i for line i) is greater than or equal to cpu_mask gives `wake` = 1 with `wake_service` = 1. This happens in the cycle after the edge that samples the request, and `halted` is 0 in that same cycle.
- R4: A qualified request whose level is below cpu_mask still wakes the CPU with the same timing, but with `wake_service` = 0 (resume).
- R5: When several sources are pending at once, `wake_service` is 1 if any one of them is enabled, and 0 only if all of them are masked.
- R6: `nmi` wakes the CPU in every mode with `wake_service` = 1, whatever the mask. `wdt_irq` wakes IDLE2 and IDLE1 with `wake_service` = 1 and is ignored in STOP.
- R7: In STOP only `nmi` and request lines 0 to 3 wake the device. Lines 4 and up leave `halted` at 1 and `wake` at 0.
- R8: In STOP, a qualified source starts the warm-up with the count `warmup_len` = L. `warming` is 1 for L+1 cycles, and then `wake` pulses. The service class is the one captured when the source arrived, even if the source is withdrawn during warm-up.
- R9: In IDLE2, request lines 4 and 5 wake the CPU only when `ext45_idle2_en` is 1. In IDLE1 they always wake it.
- R10: `wake` is high for exactly one cycle. A `halt_req` that arrives while halted is ignored, and the mode captured at halt entry is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_req | input | 1 | CPU executed the halt instruction |
| halt_mode | input | 2 | Requested low-power mode (0 IDLE2, 1 IDLE1, 2/3 STOP) |
| irq_req | input | N_IRQ | Interrupt request lines; 0-3 external low group, 4-5 external high group, rest internal |
| irq_level | input | 3*N_IRQ | Priority level per line, line i in bits 3i+2..3i |
| nmi | input | 1 | Non-maskable interrupt (fixed highest priority) |
| wdt_irq | input | 1 | Watchdog interrupt |
| cpu_mask | input | 3 | Current CPU interrupt mask |
| ext45_idle2_en | input | 1 | Lets lines 4 and 5 release IDLE2 |
| warmup_len | input | 16 | STOP warm-up count |
| wake | output | 1 | One-cycle release pulse |
| wake_service | output | 1 | With wake: 1 = service interrupt, 0 = resume |
| halted | output | 1 | CPU is held in a low-power state |
| osc_off | output | 1 | Oscillator stopped (halted in STOP) |
| warming | output | 1 | Warm-up counter running |

## Verification
Two functions can meet in one cycle. The first is classification: a masked and an enabled request sampled on the same edge. The bench raises both together in IDLE1 and in STOP, and a service result is expected exactly when at least one of them reaches the mask. The second is release against reset: reset is asserted while the warm-up count is running, and the bench judges that no wake pulse follows and that the block returns to running with every output low.

// File: rtl/halt_wake_pkg.sv
package halt_wake_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_HALT   = 2'd1,
        ST_WARMUP = 2'd2
    } hw_state_e;

    localparam logic [1:0] MODE_IDLE2 = 2'd0;
    localparam logic [1:0] MODE_IDLE1 = 2'd1;

    function automatic logic mode_is_stop(input logic [1:0] m);
        return m[1];
    endfunction

endpackage

// File: rtl/hw_src_qual.sv
module hw_src_qual
    import halt_wake_pkg::*;
#(
    parameter int N_IRQ       = 8,
    parameter int LVL_W       = 3,
    parameter int N_EXT_LO    = 4,
    parameter int EXT_HI_BASE = 4,
    parameter int N_EXT_HI    = 2
) (
    input  logic [1:0]             mode,
    input  logic [N_IRQ-1:0]       irq_req,
    input  logic [N_IRQ*LVL_W-1:0] irq_level,
    input  logic                   nmi,
    input  logic                   wdt_irq,
    input  logic [LVL_W-1:0]       cpu_mask,
    input  logic                   ext_hi_idle2_en,
    output logic                   any_wake,
    output logic                   any_service
);

    logic              stop;
    logic [N_IRQ-1:0]  allowed;
    logic [N_IRQ-1:0]  elig;
    logic [N_IRQ-1:0]  enab;
    logic              fixed_src;

    assign stop = mode_is_stop(mode);

    for (genvar i = 0; i < N_IRQ; i++) begin : g_line
        localparam bit IS_LO = (i < N_EXT_LO);
        localparam bit IS_HI = (i >= EXT_HI_BASE) && (i < EXT_HI_BASE + N_EXT_HI);
        assign allowed[i] = stop ? IS_LO
                          : ((mode == MODE_IDLE2) && IS_HI) ? ext_hi_idle2_en
                          : 1'b1;
        assign elig[i] = irq_req[i] & allowed[i];
        assign enab[i] = irq_level[i*LVL_W +: LVL_W] >= cpu_mask;
    end

    assign fixed_src   = nmi | (wdt_irq & ~stop);
    assign any_wake    = (|elig) | fixed_src;
    assign any_service = (|(elig & enab)) | fixed_src;

endmodule

// File: rtl/hw_warmup.sv
module hw_warmup #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             count_en,
    output logic             at_zero
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (count_en && (cnt != '0)) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign at_zero = (cnt == '0);

endmodule

// File: rtl/halt_wake_ctrl.sv
module halt_wake_ctrl
    import halt_wake_pkg::*;
#(
    parameter int N_IRQ = 8,
    parameter int CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 halt_req,
    input  logic [1:0]           halt_mode,
    input  logic [N_IRQ-1:0]     irq_req,
    input  logic [N_IRQ*3-1:0]   irq_level,
    input  logic                 nmi,
    input  logic                 wdt_irq,
    input  logic [2:0]           cpu_mask,
    input  logic                 ext45_idle2_en,
    input  logic [CNT_W-1:0]     warmup_len,
    output logic                 wake,
    output logic                 wake_service,
    output logic                 halted,
    output logic                 osc_off,
    output logic                 warming
);

    hw_state_e  state, state_nx;
    logic [1:0] mode_q;
    logic       svc_q;
    logic       any_wake, any_service;
    logic       cnt_zero;
    logic       stop_q;
    logic       warm_load;

    assign stop_q    = mode_is_stop(mode_q);
    assign warm_load = (state == ST_HALT) && stop_q && any_wake;

    hw_src_qual #(
        .N_IRQ(N_IRQ), .LVL_W(3), .N_EXT_LO(4), .EXT_HI_BASE(4), .N_EXT_HI(2)
    ) u_qual (
        .mode(mode_q), .irq_req(irq_req), .irq_level(irq_level),
        .nmi(nmi), .wdt_irq(wdt_irq), .cpu_mask(cpu_mask),
        .ext_hi_idle2_en(ext45_idle2_en),
        .any_wake(any_wake), .any_service(any_service)
    );

    hw_warmup #(.CNT_W(CNT_W)) u_warm (
        .clk(clk), .rst_n(rst_n), .load(warm_load), .load_val(warmup_len),
        .count_en(state == ST_WARMUP), .at_zero(cnt_zero)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:    if (halt_req) state_nx = ST_HALT;
            ST_HALT:   if (any_wake) state_nx = stop_q ? ST_WARMUP : ST_RUN;
            ST_WARMUP: if (cnt_zero) state_nx = ST_RUN;
            default:   state_nx = ST_RUN;
        endcase
    end

    // Captured mode and captured service class
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_IDLE1;
            svc_q  <= 1'b0;
        end else begin
            if ((state == ST_RUN) && halt_req) mode_q <= halt_mode;
            if (warm_load)                     svc_q  <= any_service;
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wake         <= 1'b0;
            wake_service <= 1'b0;
        end else begin
            wake         <= 1'b0;
            wake_service <= 1'b0;
            if ((state == ST_HALT) && any_wake && !stop_q) begin
                wake         <= 1'b1;
                wake_service <= any_service;
            end else if ((state == ST_WARMUP) && cnt_zero) begin
                wake         <= 1'b1;
                wake_service <= svc_q;
            end
        end
    end

    assign halted  = (state != ST_RUN);
    assign osc_off = (state == ST_HALT) && stop_q;
    assign warming = (state == ST_WARMUP);

    p_wake_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> !wake);

    p_service_with_wake_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wake_service |-> wake);

    p_stop_no_direct_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_HALT) && stop_q) |=> !wake);

    p_warm_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_WARMUP) && !cnt_zero) |=> ((state == ST_WARMUP) && !wake));

    p_masked_resume_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_HALT) && !stop_q && any_wake && !any_service) |=> (wake && !wake_service));

    p_nmi_serviced_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_HALT) && !stop_q && nmi) |=> (wake && wake_service));

endmodule

// File: tb/sim_halt_wake_ctrl.sv
module sim_halt_wake_ctrl;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         halt_req = 1'b0;
    logic [1:0]   halt_mode = 2'd1;
    logic [N-1:0] irq_req = '0;
    logic [N*3-1:0] irq_level = '0;
    logic         nmi = 1'b0;
    logic         wdt_irq = 1'b0;
    logic [2:0]   cpu_mask = 3'd0;
    logic         ext45_idle2_en = 1'b0;
    logic [15:0]  warmup_len = 16'd2;
    logic         wake, wake_service, halted, osc_off, warming;

    int checks = 0;
    int errs = 0;

    always #2 clk = ~clk;

    halt_wake_ctrl #(.N_IRQ(N), .CNT_W(16)) u0 (
        .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .halt_mode(halt_mode),
        .irq_req(irq_req), .irq_level(irq_level), .nmi(nmi), .wdt_irq(wdt_irq),
        .cpu_mask(cpu_mask), .ext45_idle2_en(ext45_idle2_en), .warmup_len(warmup_len),
        .wake(wake), .wake_service(wake_service), .halted(halted),
        .osc_off(osc_off), .warming(warming)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_src();
        irq_req = '0;
        nmi = 1'b0;
        wdt_irq = 1'b0;
    endtask

    task automatic enter_halt(input logic [1:0] m);
        @(negedge clk);
        halt_mode = m;
        halt_req = 1'b1;
        @(negedge clk);
        halt_req = 1'b0;
        chk("R2 halted", halted, 1);
        chk("R2 osc_off", osc_off, m[1]);
    endtask

    // Called at the negedge on which the source was raised.
    task automatic expect_wake(input logic stop, input logic svc, input string tag);
        if (stop) begin
            for (int k = 0; k <= int'(warmup_len); k++) begin
                @(negedge clk);
                chk("R8 warming", warming, 1);
                chk("R8 no early wake", wake, 0);
                if (k == 0) clear_src();
            end
        end
        @(negedge clk);
        chk(tag, wake, 1);
        chk(tag, wake_service, svc);
        chk("R10 halted low at wake", halted, 0);
        clear_src();
        @(negedge clk);
        chk("R10 wake one cycle", wake, 0);
    endtask

    task automatic expect_none(input string tag);
        for (int k = 0; k < int'(warmup_len) + 3; k++) begin
            @(negedge clk);
            chk(tag, wake, 0);
            chk(tag, halted, 1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL watchdog timeout actual=1 expected=0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset halted", halted, 0);
        chk("R1 reset wake", wake, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 halted", halted, 0);
        chk("R1 wake", wake, 0);
        chk("R1 service", wake_service, 0);
        chk("R1 osc_off", osc_off, 0);
        chk("R1 warming", warming, 0);

        // Sweep: line x mode x gate x level x mask
        warmup_len = 16'd2;
        for (int ln = 0; ln < N; ln++) begin
            for (int md = 0; md < 3; md++) begin
                for (int en = 0; en < 2; en++) begin
                    for (int lv = 0; lv < 8; lv++) begin
                        for (int mk = 0; mk < 8; mk++) begin
                            logic elig;
                            logic svc;
                            string tag;
                            cpu_mask = 3'(mk);
                            ext45_idle2_en = en[0];
                            irq_level = {N{3'(lv)}};
                            enter_halt(2'(md));
                            if (md == 2) begin
                                elig = (ln < 4);
                                tag = "R7 stop source";
                            end else if (md == 0 && (ln == 4 || ln == 5)) begin
                                elig = en[0];
                                tag = "R9 idle2 gate";
                            end else begin
                                elig = 1'b1;
                                tag = (lv >= mk) ? "R3 enabled" : "R4 masked";
                            end
                            svc = (lv >= mk);
                            irq_req[ln] = 1'b1;
                            if (elig) begin
                                expect_wake(md == 2, svc, tag);
                            end else begin
                                expect_none(tag);
                                irq_req = '0;
                                nmi = 1'b1;
                                expect_wake(md == 2, 1'b1, "R6 nmi release");
                            end
                        end
                    end
                end
            end
        end

        // R5 mixtures
        cpu_mask = 3'd5;
        irq_level = '0;
        irq_level[18 +: 3] = 3'd2;
        irq_level[21 +: 3] = 3'd6;
        enter_halt(2'd1);
        irq_req[6] = 1'b1; irq_req[7] = 1'b1;
        expect_wake(1'b0, 1'b1, "R5 mixed enabled");
        irq_level[21 +: 3] = 3'd4;
        enter_halt(2'd1);
        irq_req[6] = 1'b1; irq_req[7] = 1'b1;
        expect_wake(1'b0, 1'b0, "R5 all masked");
        cpu_mask = 3'd4;
        irq_level[0 +: 3] = 3'd1;
        irq_level[3 +: 3] = 3'd7;
        enter_halt(2'd2);
        irq_req[0] = 1'b1; irq_req[1] = 1'b1;
        expect_wake(1'b1, 1'b1, "R5 stop mixed");

        // R6 watchdog
        cpu_mask = 3'd7;
        enter_halt(2'd0);
        wdt_irq = 1'b1;
        expect_wake(1'b0, 1'b1, "R6 wdt idle2");
        enter_halt(2'd2);
        wdt_irq = 1'b1;
        expect_none("R6 wdt ignored in stop");
        wdt_irq = 1'b0;
        nmi = 1'b1;
        expect_wake(1'b1, 1'b1, "R6 nmi stop");

        // R8 other warm-up lengths
        cpu_mask = 3'd0;
        irq_level = '0;
        warmup_len = 16'd0;
        enter_halt(2'd3);
        irq_req[2] = 1'b1;
        expect_wake(1'b1, 1'b1, "R8 zero warmup");
        warmup_len = 16'd9;
        cpu_mask = 3'd3;
        enter_halt(2'd2);
        irq_req[3] = 1'b1;
        expect_wake(1'b1, 1'b0, "R8 long warmup masked");

        // R10 halt_req ignored while halted
        warmup_len = 16'd2;
        cpu_mask = 3'd0;
        enter_halt(2'd1);
        @(negedge clk);
        halt_mode = 2'd2;
        halt_req = 1'b1;
        @(negedge clk);
        halt_req = 1'b0;
        chk("R10 mode kept osc_off", osc_off, 0);
        chk("R10 still halted", halted, 1);
        irq_req[6] = 1'b1;
        expect_wake(1'b0, 1'b1, "R10 idle wake kept");

        // R1 reset during warm-up
        enter_halt(2'd2);
        irq_req[0] = 1'b1;
        @(negedge clk);
        chk("R1 warming before reset", warming, 1);
        rst_n = 1'b0;
        #1;
        chk("R1 reset halted", halted, 0);
        chk("R1 reset warming", warming, 0);
        chk("R1 reset wake", wake, 0);
        @(negedge clk);
        rst_n = 1'b1;
        irq_req = '0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk("R1 no wake after reset", wake, 0);
            chk("R1 running after reset", halted, 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end

endmodule